// File: doc/BRIEF.md
# Two-to-four-phase handshake converter

This block joins a transition-signalling (two-phase) push channel to a level-signalling, return-to-zero (four-phase) push channel that carries bundled single-rail data. On the upstream side, any change of the request toggle, rising or falling, announces one new data word. Each completed transfer is answered by one change of the acknowledge toggle. On the downstream side, the converter runs one full four-phase cycle for each announced word: request high, acknowledge high, request low, acknowledge low. It holds the word in an output register for the whole cycle.

The whole block runs in one clock domain and samples every handshake line on the rising clock edge. The upstream acknowledge changes only after the downstream acknowledge has returned low. So the source never sees its word consumed until the four-phase side is idle again. A request change that arrives while a downstream cycle is still open stays pending and is served once that cycle finishes.

Top module: `phase_bridge`

## Requirements
- R1: After reset, dn_req and up_ack are 0, dn_data is all zeros, and the stored copy of up_req is 0. An up_req held at 0 therefore starts no transfer.
- R2: A sampled up_req value that differs from the last accepted one, whether a 0-to-1 or a 1-to-0 change, is one event. When the downstream side is idle, dn_req goes high in the clock cycle after the edge that samples the change.
- R3: dn_data takes the up_data value sampled at the same edge that raises dn_req.
- R4: dn_data changes only at an edge that raises dn_req. It stays unchanged through the whole four-phase cycle and afterwards, whatever up_data does.
- R5: dn_req stays high while dn_ack is sampled low. It falls at the first edge that samples dn_ack high.
- R6: up_ack changes exactly once per transfer. It changes at the first edge that samples dn_ack low after dn_req has fallen, and never while dn_req is high or dn_ack is still high.
- R7: While up_req does not change, no new transfer starts and dn_req stays low.
- R8: An up_req change that arrives while a four-phase cycle is open is kept pending. dn_req rises for it one edge after up_ack changes, and dn_data carries the up_data present at that edge.
- R9: dn_ack going high while no transfer is open has no effect on dn_req, up_ack or dn_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all lines sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| up_req | input | 1 | Upstream request toggle; each change announces a word |
| up_ack | output | 1 | Upstream acknowledge toggle; each change reports a consumed word |
| up_data | input | W | Upstream data word |
| dn_req | output | 1 | Downstream four-phase request level |
| dn_ack | input | 1 | Downstream four-phase acknowledge level |
| dn_data | output | W | Registered downstream data word |

## Verification
The main transfer is swept over every pair of delays from zero to three cycles, one delay before the sink raises its acknowledge and one before it drops it. Because each transfer flips the request toggle, rising and falling request changes alternate, which shows that both edge directions count as events. Each delay pair uses several data words, and up_data is changed during the open cycle. This separates a word that is really held from one that merely passes through. Separate runs cover a request change made inside an open cycle, which must wait and then carry its own word, and an acknowledge pulse while idle, which must do nothing.

// File: rtl/pb_pkg.sv
package pb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_RAISED  = 2'd1,
    PH_LOWERED = 2'd2
  } phase_t;

  // a new upstream event exists when the toggle differs from its stored copy
  function automatic logic has_event(input logic now_lvl, input logic seen_lvl);
    return now_lvl ^ seen_lvl;
  endfunction

  function automatic phase_t next_phase(input phase_t cur, input logic ev,
                                        input logic ack_lvl);
    phase_t nxt;
    nxt = cur;
    case (cur)
      PH_IDLE:    if (ev)       nxt = PH_RAISED;
      PH_RAISED:  if (ack_lvl)  nxt = PH_LOWERED;
      PH_LOWERED: if (!ack_lvl) nxt = PH_IDLE;
      default:                  nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/pb_event_track.sv
module pb_event_track (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl,
  input  logic accept,
  output logic pending
);
  import pb_pkg::*;

  logic seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      seen_q <= 1'b0;
    else if (accept) seen_q <= req_tgl;
  end

  assign pending = has_event(req_tgl, seen_q);

endmodule

// File: rtl/pb_phase_ctrl.sv
module pb_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic dn_ack,
  output logic accept,
  output logic finish,
  output logic dn_req
);
  import pb_pkg::*;

  phase_t phase_q;

  assign accept = (phase_q == PH_IDLE) && pending;
  assign finish = (phase_q == PH_LOWERED) && !dn_ack;
  assign dn_req = (phase_q == PH_RAISED);

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= next_phase(phase_q, pending, dn_ack);
  end

endmodule

// File: rtl/pb_word_reg.sv
module pb_word_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/pb_ack_tgl.sv
module pb_ack_tgl (
  input  logic clk,
  input  logic rst_n,
  input  logic finish,
  output logic ack_tgl
);

  always_ff @(posedge clk) begin
    if (!rst_n)      ack_tgl <= 1'b0;
    else if (finish) ack_tgl <= ~ack_tgl;
  end

endmodule

// File: rtl/phase_bridge.sv
module phase_bridge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_req,
  output logic         up_ack,
  input  logic [W-1:0] up_data,
  output logic         dn_req,
  input  logic         dn_ack,
  output logic [W-1:0] dn_data
);

  // named internal events, visible to the bound checker
  logic pending;
  logic accept;
  logic finish;

  pb_event_track u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_tgl (up_req),
    .accept  (accept),
    .pending (pending)
  );

  pb_phase_ctrl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .pending (pending),
    .dn_ack  (dn_ack),
    .accept  (accept),
    .finish  (finish),
    .dn_req  (dn_req)
  );

  pb_word_reg #(.W(W)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .d     (up_data),
    .q     (dn_data)
  );

  pb_ack_tgl u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .finish  (finish),
    .ack_tgl (up_ack)
  );

endmodule

// File: rtl/pb_checker.sv
module pb_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         up_req,
  input logic         up_ack,
  input logic         dn_req,
  input logic         dn_ack,
  input logic [W-1:0] dn_data,
  input logic         pending,
  input logic         accept
);

  p_start_on_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> $past(pending));

  p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && !dn_ack) |=> dn_req);

  p_drop_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_ack) |=> !dn_req);

  p_word_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(dn_req) |-> $stable(dn_data));

  p_ack_after_rtz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ack != $past(up_ack)) |-> (!dn_req && !$past(dn_req) && !$past(dn_ack)));

  p_ack_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (up_ack == $past(up_ack)));

  p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !accept) |=> (pending || (up_req != $past(up_req))));

endmodule

bind phase_bridge pb_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .up_req  (up_req),
  .up_ack  (up_ack),
  .dn_req  (dn_req),
  .dn_ack  (dn_ack),
  .dn_data (dn_data),
  .pending (pending),
  .accept  (accept)
);

// File: tb/phase_bridge_test.sv
module phase_bridge_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up_req = 1'b0;
  logic         up_ack;
  logic [W-1:0] up_data = '0;
  logic         dn_req;
  logic         dn_ack = 1'b0;
  logic [W-1:0] dn_data;

  int checks = 0;
  int errors = 0;
  logic exp_ack = 1'b0;
  logic [W-1:0] last_word = '0;

  always #10 clk = ~clk;

  phase_bridge #(.W(W)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_req  (up_req),
    .up_ack  (up_ack),
    .up_data (up_data),
    .dn_req  (dn_req),
    .dn_ack  (dn_ack),
    .dn_data (dn_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // one full transfer with the sink waiting hi cycles before ack rises
  // and lo cycles before ack falls
  task automatic xfer(input logic [W-1:0] d, input int hi, input int lo);
    @(negedge clk);
    up_data = d;
    up_req  = ~up_req;
    @(negedge clk);
    check(dn_req == 1'b1, "R2 dn_req rise", int'(dn_req), 1);
    check(dn_data == d, "R3 captured word", int'(dn_data), int'(d));
    up_data = ~d;
    for (int i = 0; i < hi; i++) begin
      @(negedge clk);
      check(dn_req == 1'b1, "R5 req held", int'(dn_req), 1);
      check(dn_data == d, "R4 word held", int'(dn_data), int'(d));
      check(up_ack == exp_ack, "R6 ack quiet", int'(up_ack), int'(exp_ack));
    end
    dn_ack = 1'b1;
    @(negedge clk);
    check(dn_req == 1'b0, "R5 req drop", int'(dn_req), 0);
    check(dn_data == d, "R4 word held", int'(dn_data), int'(d));
    for (int i = 0; i < lo; i++) begin
      @(negedge clk);
      check(up_ack == exp_ack, "R6 ack waits rtz", int'(up_ack), int'(exp_ack));
      check(dn_req == 1'b0, "R5 req low", int'(dn_req), 0);
    end
    dn_ack = 1'b0;
    @(negedge clk);
    exp_ack = ~exp_ack;
    check(up_ack == exp_ack, "R6 ack toggle", int'(up_ack), int'(exp_ack));
    check(dn_data == d, "R4 word after", int'(dn_data), int'(d));
    last_word = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check(dn_req == 1'b0, "R1 reset dn_req", int'(dn_req), 0);
    check(up_ack == 1'b0, "R1 reset up_ack", int'(up_ack), 0);
    check(dn_data == '0, "R1 reset dn_data", int'(dn_data), 0);

    // R7: no toggle, no transfer
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(dn_req == 1'b0, "R7 idle no req", int'(dn_req), 0);
    end

    // sweep of sink delays and words; toggle direction alternates each transfer
    for (int hi = 0; hi < 4; hi++)
      for (int lo = 0; lo < 4; lo++)
        for (int k = 0; k < 3; k++)
          xfer(W'(((hi * 4 + lo) * 17) ^ (k * 8'h5A)), hi, lo);

    // R9: ack pulse while idle
    @(negedge clk);
    dn_ack = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(dn_req == 1'b0, "R9 idle ack no req", int'(dn_req), 0);
      check(up_ack == exp_ack, "R9 idle ack no toggle", int'(up_ack), int'(exp_ack));
      check(dn_data == last_word, "R9 idle ack word", int'(dn_data), int'(last_word));
    end
    dn_ack = 1'b0;
    repeat (2) @(negedge clk);
    check(dn_req == 1'b0, "R7 still idle", int'(dn_req), 0);

    // R8: event arriving inside an open cycle
    @(negedge clk);
    up_data = 8'hA5;
    up_req  = ~up_req;
    @(negedge clk);
    check(dn_req == 1'b1, "R2 first req", int'(dn_req), 1);
    up_data = 8'h3C;
    up_req  = ~up_req;
    @(negedge clk);
    check(dn_req == 1'b1, "R8 busy req held", int'(dn_req), 1);
    check(dn_data == 8'hA5, "R8 first word kept", int'(dn_data), 8'hA5);
    dn_ack = 1'b1;
    @(negedge clk);
    check(dn_req == 1'b0, "R5 drop", int'(dn_req), 0);
    dn_ack = 1'b0;
    @(negedge clk);
    exp_ack = ~exp_ack;
    check(up_ack == exp_ack, "R6 first ack", int'(up_ack), int'(exp_ack));
    check(dn_req == 1'b0, "R8 not yet", int'(dn_req), 0);
    @(negedge clk);
    check(dn_req == 1'b1, "R8 pending served", int'(dn_req), 1);
    check(dn_data == 8'h3C, "R8 pending word", int'(dn_data), 8'h3C);
    up_data = 8'hFF;
    dn_ack = 1'b1;
    @(negedge clk);
    dn_ack = 1'b0;
    @(negedge clk);
    exp_ack = ~exp_ack;
    check(up_ack == exp_ack, "R8 second ack", int'(up_ack), int'(exp_ack));
    repeat (3) @(negedge clk);
    check(dn_req == 1'b0, "R8 no extra transfer", int'(dn_req), 0);
    check(up_ack == exp_ack, "R6 no extra ack", int'(up_ack), int'(exp_ack));

    summary();
    $finish;
  end

endmodule